// File: doc/BRIEF.md
# Shift-Coefficient Multi-Channel Smoothing Filter

This block sits after an ADC that converts several differential channels in turn. Each converted sample arrives with a channel index. The block keeps one first-order recursive low-pass state per channel. On each sample it moves that channel's state toward the new value by a power-of-two fraction of the difference, so the update needs only a subtract, an arithmetic shift and an add. A 3-bit select chooses the fraction, and that fraction applies to every channel. The block produces a filtered result only while the filter is enabled and samples keep arriving.

Each channel has a two-state machine. In `CH_COLD` the channel has no history. In `CH_WARM` the channel holds a valid filter state. The three transitions are:
- `LOAD` (`CH_COLD`→`CH_WARM`): the channel's first accepted sample is copied straight into the state.
- `FILTER` (`CH_WARM`→`CH_WARM`): each later sample updates the state recursively.
- `DROP` (any→`CH_COLD`): taken by every channel while enable is low.

This arrangement lets the filter settle quickly after start-up, because a channel begins from its first real reading instead of from zero. The state keeps 8 fractional bits below the input LSB, and the output is rounded back to the input width.

Top module: `shift_lpf_bank`

## Requirements
- R1: Each channel keeps its own state y. This state has 8 fractional bits, so the stored value is the real value times 256. A sample x accepted on a `CH_WARM` channel sets y to y + ((x·256 − y) >>> k), where >>> is an arithmetic shift that rounds toward minus infinity. No other channel's state changes.
- R2: `coef_sel` codes 0,1,2,3,4,5,6 give shifts k = 1,2,3,4,5,6,7. Code 7 gives k = 7. The current code applies to whichever channel is being updated.
- R3: While `enable` is low, `out_valid` stays low one clock later and the incoming sample is ignored.
- R4: The output is rounded as follows: `out_data` = (y + 128) >>> 8, truncated to the input width.
- R5: The first sample a channel accepts after being `CH_COLD` becomes its state unfiltered. The corresponding `out_data` equals that input sample.
- R6: A low `enable` in any cycle sends every channel to `CH_COLD`. After `enable` returns high, each channel's next sample is loaded as in R5.
- R7: `out_valid` is high exactly one clock after a cycle with `in_valid` and `enable` both high. In that cycle `out_chan` equals that sample's channel index.
- R8: At k = 7 there is no truncation dead-band. A constant input held long enough drives `out_data` exactly to that input.
- R9: Samples are two's complement signed values, and negative inputs and states are filtered by the same rule as positive ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Filter on; while low, all channels go `CH_COLD` |
| coef_sel | input | 3 | Shared shift select (code c gives shift c+1, and 7 gives 7) |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | CW (3) | Channel index of the sample |
| in_data | input | DW (16) | Signed sample |
| out_valid | output | 1 | Result strobe, one clock after an accepted sample |
| out_chan | output | CW (3) | Channel of the result |
| out_data | output | DW (16) | Rounded signed filtered value |

## Verification
The colliding pair is a channel's `FILTER` update and the `DROP` caused by a low `enable`. The bench provokes this by lowering `enable` in the same cycle that a sample arrives for a warm channel. The expected outcome has three parts: no result strobe follows, the held state is discarded, and the first sample after re-enable comes out equal to its input rather than blended with the old state. A second overlap is `enable` rising together with a sample, which must produce a `LOAD`.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
    typedef enum logic {
        CH_COLD = 1'b0,
        CH_WARM = 1'b1
    } ch_state_e;
endpackage

// File: rtl/lpf_shift_decode.sv
module lpf_shift_decode (
    input  logic [2:0] sel,
    output logic [2:0] shamt
);
    always_comb begin
        unique case (sel)
            3'd0: shamt = 3'd1;
            3'd1: shamt = 3'd2;
            3'd2: shamt = 3'd3;
            3'd3: shamt = 3'd4;
            3'd4: shamt = 3'd5;
            3'd5: shamt = 3'd6;
            3'd6: shamt = 3'd7;
            3'd7: shamt = 3'd7; // reserved code, same as slowest
        endcase
    end
endmodule

// File: rtl/lpf_update.sv
module lpf_update #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    localparam int SW  = DW + FRAC
) (
    input  logic signed [DW-1:0] x,
    input  logic signed [SW-1:0] y_old,
    input  logic        [2:0]    shamt,
    output logic signed [SW-1:0] y_new
);
    logic signed [SW:0] x_ext;
    logic signed [SW:0] diff;
    logic signed [SW:0] step;
    logic signed [SW:0] sum;

    always_comb begin
        x_ext = {x[DW-1], x, {FRAC{1'b0}}};
        diff  = x_ext - {y_old[SW-1], y_old};
        step  = diff >>> shamt;
        sum   = {y_old[SW-1], y_old} + step;
        // The sum lies between y_old and x, so it always fits in SW bits.
        y_new = sum[SW-1:0];
    end
endmodule

// File: rtl/lpf_round.sv
module lpf_round #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    localparam int SW  = DW + FRAC
) (
    input  logic signed [SW-1:0] y,
    output logic signed [DW-1:0] q
);
    localparam logic [SW:0] HALF = (SW+1)'(1) << (FRAC - 1);
    logic signed [SW:0] biased;

    always_comb begin
        biased = {y[SW-1], y} + HALF;
        q      = biased[SW-1:FRAC];
    end
endmodule

// File: rtl/shift_lpf_bank.sv
module shift_lpf_bank #(
    parameter int NCH  = 8,
    parameter int DW   = 16,
    parameter int FRAC = 8,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int SW  = DW + FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [2:0]           coef_sel,
    input  logic                 in_valid,
    input  logic [CW-1:0]        in_chan,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic [CW-1:0]        out_chan,
    output logic signed [DW-1:0] out_data
);
    import lpf_pkg::*;

    ch_state_e          ch_st  [NCH];
    logic signed [SW-1:0] ch_acc [NCH];

    logic               accept;
    ch_state_e          sel_st;
    logic signed [SW-1:0] sel_acc;
    logic [2:0]         shamt;
    logic signed [SW-1:0] filt_acc;
    logic signed [SW-1:0] nxt_acc;
    logic signed [DW-1:0] nxt_q;

    assign accept  = in_valid && enable;
    assign sel_st  = ch_st[in_chan];
    assign sel_acc = ch_acc[in_chan];

    lpf_shift_decode u_dec (
        .sel   (coef_sel),
        .shamt (shamt)
    );

    lpf_update #(.DW(DW), .FRAC(FRAC)) u_upd (
        .x     (in_data),
        .y_old (sel_acc),
        .shamt (shamt),
        .y_new (filt_acc)
    );

    // LOAD takes the raw sample; FILTER takes the recursive update.
    always_comb begin
        unique case (sel_st)
            CH_COLD: nxt_acc = {in_data, {FRAC{1'b0}}};
            CH_WARM: nxt_acc = filt_acc;
        endcase
    end

    lpf_round #(.DW(DW), .FRAC(FRAC)) u_rnd (
        .y (nxt_acc),
        .q (nxt_q)
    );

    // Per-channel state register: LOAD, FILTER, DROP.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_st[g]  <= CH_COLD;
                ch_acc[g] <= '0;
            end else if (!enable) begin
                ch_st[g]  <= CH_COLD;
            end else if (accept && (in_chan == CW'(g))) begin
                ch_st[g]  <= CH_WARM;
                ch_acc[g] <= nxt_acc;
            end
        end

        p_drop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !enable |=> (ch_st[g] == CH_COLD));
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_chan <= in_chan;
                out_data <= nxt_q;
            end
        end
    end

    p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !out_valid);

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && enable));

    p_chan_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chan == $past(in_chan)));

    p_preload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel_st == CH_COLD) |=> (out_data == $past(in_data)));
endmodule

// File: tb/shift_lpf_bank_bench.sv
module shift_lpf_bank_bench;
    localparam int NCH = 8;
    localparam int DW  = 16;
    localparam int CW  = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 enable = 1'b0;
    logic [2:0]           coef_sel = 3'd0;
    logic                 in_valid = 1'b0;
    logic [CW-1:0]        in_chan = '0;
    logic signed [DW-1:0] in_data = '0;
    logic                 out_valid;
    logic [CW-1:0]        out_chan;
    logic signed [DW-1:0] out_data;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    longint ref_y [NCH];
    bit     warm  [NCH];

    always #2.5 clk = ~clk;

    shift_lpf_bank #(.NCH(NCH), .DW(DW)) u_shift_lpf_bank (
        .clk, .rst_n, .enable, .coef_sel, .in_valid, .in_chan, .in_data,
        .out_valid, .out_chan, .out_data
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int kof(input logic [2:0] s);
        return (s == 3'd7) ? 7 : int'(s) + 1;
    endfunction

    // One sample, with enable driven at the same time; checks the next cycle.
    task automatic send(input int ch, input int x, input bit en);
        longint d, expq;
        @(negedge clk);
        enable   = en;
        in_valid = 1'b1;
        in_chan  = CW'(ch);
        in_data  = DW'(x);
        @(negedge clk);
        in_valid = 1'b0;
        if (!en) begin
            for (int i = 0; i < NCH; i++) warm[i] = 0;
            chk(out_valid == 1'b0, "R3", out_valid, 0);
        end else begin
            if (!warm[ch]) begin
                ref_y[ch] = longint'(x) * 256;
                warm[ch] = 1;
            end else begin
                d = longint'(x) * 256 - ref_y[ch];
                ref_y[ch] = ref_y[ch] + (d >>> kof(coef_sel));
            end
            expq = (ref_y[ch] + 128) >>> 8;
            chk(out_valid == 1'b1, "R7 valid", out_valid, 1);
            chk(out_chan == CW'(ch), "R7 chan", out_chan, ch);
            chk(longint'(out_data) == expq, "R1 value", out_data, expq);
        end
    endtask

    task automatic go_off;
        @(negedge clk);
        enable = 1'b0;
        for (int i = 0; i < NCH; i++) warm[i] = 0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "reset valid", out_valid, 0);
        chk(out_data == '0, "reset data", out_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R3 idle", out_valid, 0);
    endtask

    task automatic t_preload;
        coef_sel = 3'd4;
        send(0, 1234, 1);
        chk(out_data == 16'sd1234, "R5 preload", out_data, 1234);
        send(1, -777, 1);
        chk(out_data == -16'sd777, "R5 preload neg", out_data, -777);
        send(0, 1234 + 320, 1); // (320*256)>>>5 = 2560 -> +10
        chk(out_data == 16'sd1244, "R1 step k5", out_data, 1244);
    endtask

    task automatic t_codes;
        for (int c = 0; c < 8; c++) begin
            go_off();
            coef_sel = 3'(c);
            send(2, 0, 1);
            send(2, 1024, 1);
            chk(longint'(out_data) == (1024 >> kof(3'(c))), "R2 code", out_data, 1024 >> kof(3'(c)));
        end
    endtask

    task automatic t_round;
        go_off();
        coef_sel = 3'd0;
        send(4, 0, 1);
        send(4, 1, 1);   // y=128 -> rounds up to 1
        chk(out_data == 16'sd1, "R4 half up", out_data, 1);
        send(4, 0, 1);   // y=64 -> 0
        chk(out_data == 16'sd0, "R4 below half", out_data, 0);
        send(5, 0, 1);
        send(5, -1, 1);  // y=-128 -> 0
        chk(out_data == 16'sd0, "R9 neg half", out_data, 0);
        send(5, -1000, 1);
        send(5, -3000, 1);
        send(5, 5000, 1);
    endtask

    task automatic t_disable;
        enable = 1'b1;
        send(6, 500, 1);
        send(6, 900, 0);          // R3: ignored
        send(6, -200, 1);         // R6: reloads
        chk(out_data == -16'sd200, "R6 reload", out_data, -200);
    endtask

    task automatic t_collision;
        coef_sel = 3'd2;
        send(7, 100, 1);
        send(7, 400, 1);
        send(3, 50, 1);
        send(7, 8000, 0);         // FILTER vs DROP in same cycle
        send(7, 300, 1);          // enable rises with a sample: LOAD
        chk(out_data == 16'sd300, "R6 collide reload", out_data, 300);
        send(3, 60, 1);
        chk(out_data == 16'sd60, "R5 other chan cold", out_data, 60);
    endtask

    task automatic t_interleave;
        coef_sel = 3'd1;
        for (int i = 0; i < 24; i++) send(i % NCH, (i * 937) % 4000 - 2000, 1);
    endtask

    task automatic t_settle;
        go_off();
        coef_sel = 3'd6;
        send(3, 0, 1);
        for (int i = 0; i < 2000; i++) send(3, 100, 1);
        chk(out_data == 16'sd100, "R8 no dead-band", out_data, 100);
        coef_sel = 3'd7;
        for (int i = 0; i < 2000; i++) send(3, -100, 1);
        chk(out_data == -16'sd100, "R8 R9 neg settle", out_data, -100);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            ref_y[i] = 0;
            warm[i] = 0;
        end
        t_reset();
        t_preload();
        t_codes();
        t_round();
        t_disable();
        t_collision();
        t_interleave();
        t_settle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #150000;
        if (!done) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule